// File: doc/BRIEF.md
# Color Palette Host Access Controller

This block holds the color lookup table of a video palette together with the registers a host processor uses to reach it. The host drives a 4-bit register select, an 8-bit data input and separate write and read strobes. Each strobe is brought into the block's clock domain by a synchronizer, so the host may run without any relation to the pixel clock. A 256-entry by 24-bit RAM stores one red, green and blue byte per entry. The host reaches the RAM through a holding register, one byte at a time, and two separate pointers step through the table. One pointer serves writes and the other serves reads. Because each pointer advances on its own, the whole table can be streamed in or out after a single address write.

On the pixel side, an index is ANDed with a read mask and looks up one entry. The entry appears as a 24-bit color one clock later. A compatibility input selects 6-bit operation. In that mode all 8 written bits are still stored. Host readback of color bytes then returns the top two bits as zero. The pixel path shifts each component left by two and fills the low bits with zero.

Top module: `palette_host_ctl`

## Requirements
- R1: Register select code 0x0 is the write pointer and 0x3 is the read pointer. Reading either code returns that pointer's current value. Code 0x2 is the pixel read mask, which can be written and read back.
- R2: Codes 0x8, 0x9, 0xA, 0xB, 0xC and 0xE are 8-bit control registers. Each one returns the last value written to it.
- R3: Reserved codes 0x4 to 0x7 and 0xD read as 0, and writes to them change no register. A write to code 0xF clears all six control registers to 0.
- R4: Writes to code 0x1 are taken as red, then green, then blue. Only the blue write stores {red,green,blue} at the write pointer, with red in bits 23:16, and then adds 1 to the write pointer.
- R5: Writing a value N to code 0x3 loads entry N into the holding register and sets the read pointer to N+1. Reads of code 0x1 then return red, green and blue in that order. The blue read loads the entry at the read pointer and then adds 1 to the read pointer.
- R6: Both pointers wrap from 255 to 0.
- R7: A write to code 0x0 or code 0x3 makes the next holding-register access the red byte.
- R8: While mode8 is 0, host reads of code 0x1 return bits 7:6 as 0. The stored bits are kept, and they read back in full once mode8 is 1.
- R9: pix_rgb holds the entry at (pix_idx AND mask), one clock after pix_idx is applied. While mode8 is 0, each component c is output as {c[5:0],2'b00}.
- R10: An access takes place once per rising edge of a strobe, however long the strobe stays high. It completes within 3 clocks of that edge. reg_sel and din must stay stable while the strobe is high.
- R11: After reset both pointers are 0, the byte sequence is at red, the mask is 0xFF, the control registers are 0, and dout and pix_rgb are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_strobe | input | 1 | Host write strobe, asynchronous, active high |
| rd_strobe | input | 1 | Host read strobe, asynchronous, active high |
| reg_sel | input | 4 | Register select code |
| din | input | 8 | Host write data |
| mode8 | input | 1 | 1 = full 8-bit color, 0 = 6-bit compatibility |
| pix_idx | input | 8 | Pixel palette index |
| dout | output | 8 | Host read data, held until the next read |
| pix_rgb | output | 24 | Pixel color {red,green,blue} |

## Verification
The assertions check the following on every cycle:
- the write pointer steps by one after each blue write, wrapping from 255 to 0;
- a read-pointer write loads N+1;
- an address write restarts the byte sequence;
- in 6-bit mode, color readback has its top bits zeroed;
- in 6-bit mode, the pixel output has its low bits zeroed.

Only the bench scenarios can show that stored data survives. They check that the three bytes land in the right entry and come back in order, and that full 8-bit values reappear after a mode switch. They also confirm that reserved codes really change nothing, that the clear code resets the control registers, and that a held strobe makes only one access.

// File: rtl/palette_host_ctl.sv
module palette_host_ctl #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_strobe,
  input  logic            rd_strobe,
  input  logic [3:0]      reg_sel,
  input  logic [CW-1:0]   din,
  input  logic            mode8,
  input  logic [AW-1:0]   pix_idx,
  output logic [CW-1:0]   dout,
  output logic [3*CW-1:0] pix_rgb
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = 3 * CW;
  localparam logic [CW-1:0] LOW6 = {2'b00, {(CW-2){1'b1}}};

  logic [2:0]    wr_sy, rd_sy;
  logic          wr_evt, rd_evt;
  logic [EW-1:0] ram [DEPTH];
  logic [CW-1:0] ctl [8];
  logic [AW-1:0] wr_ptr, rd_ptr, mask;
  logic [1:0]    seq;
  logic [EW-1:0] hold;
  logic [CW-1:0] comp;
  logic [EW-1:0] pix_ent;
  logic          ctl_ok;

  assign wr_evt  = wr_sy[1] & ~wr_sy[2];
  assign rd_evt  = rd_sy[1] & ~rd_sy[2];
  assign ctl_ok  = reg_sel[3] && (reg_sel[2:0] != 3'd5) && (reg_sel[2:0] != 3'd7);
  assign pix_ent = ram[pix_idx & mask];

  always_comb begin
    case (seq)
      2'd0:    comp = hold[EW-1:2*CW];
      2'd1:    comp = hold[2*CW-1:CW];
      default: comp = hold[CW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sy <= '0;
      rd_sy <= '0;
    end else begin
      wr_sy <= {wr_sy[1:0], wr_strobe};
      rd_sy <= {rd_sy[1:0], rd_strobe};
    end
  end

  always_ff @(posedge clk)
    if (wr_evt && reg_sel == 4'h1 && seq == 2'd2)
      ram[wr_ptr] <= {hold[EW-1:CW], din};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      mask    <= '1;
      seq     <= '0;
      hold    <= '0;
      dout    <= '0;
      pix_rgb <= '0;
      for (int i = 0; i < 8; i++) ctl[i] <= '0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (mode8) pix_rgb[k*CW +: CW] <= pix_ent[k*CW +: CW];
        else       pix_rgb[k*CW +: CW] <= {pix_ent[k*CW +: CW-2], 2'b00};
      end
      if (wr_evt) begin
        case (reg_sel)
          4'h0: begin wr_ptr <= din[AW-1:0]; seq <= '0; end
          4'h1: begin
            case (seq)
              2'd0:    begin hold[EW-1:2*CW] <= din; seq <= 2'd1; end
              2'd1:    begin hold[2*CW-1:CW] <= din; seq <= 2'd2; end
              default: begin hold[CW-1:0] <= din; seq <= '0; wr_ptr <= wr_ptr + 1'b1; end
            endcase
          end
          4'h2: mask <= din[AW-1:0];
          4'h3: begin
            hold   <= ram[din[AW-1:0]];
            rd_ptr <= din[AW-1:0] + 1'b1;
            seq    <= '0;
          end
          4'hF: for (int i = 0; i < 8; i++) ctl[i] <= '0;
          default: if (ctl_ok) ctl[reg_sel[2:0]] <= din;
        endcase
      end else if (rd_evt) begin
        case (reg_sel)
          4'h0: dout <= CW'(wr_ptr);
          4'h1: begin
            dout <= mode8 ? comp : (comp & LOW6);
            if (seq == 2'd2) begin
              seq    <= '0;
              hold   <= ram[rd_ptr];
              rd_ptr <= rd_ptr + 1'b1;
            end else begin
              seq <= seq + 1'b1;
            end
          end
          4'h2: dout <= CW'(mask);
          4'h3: dout <= CW'(rd_ptr);
          default: dout <= ctl_ok ? ctl[reg_sel[2:0]] : '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/palette_host_ctl_sva.sv
module palette_host_ctl_sva #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      reg_sel,
  input logic [CW-1:0]   din,
  input logic            mode8,
  input logic [CW-1:0]   dout,
  input logic [3*CW-1:0] pix_rgb,
  input logic            wr_evt,
  input logic            rd_evt,
  input logic [1:0]      seq,
  input logic [AW-1:0]   wr_ptr,
  input logic [AW-1:0]   rd_ptr
);
  assert_wrptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && reg_sel == 4'h1 && seq == 2'd2) |=> (wr_ptr == AW'($past(wr_ptr) + AW'(1))));

  assert_wrptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && reg_sel == 4'h1 && seq == 2'd2 && wr_ptr == '1) |=> (wr_ptr == '0));

  assert_rdptr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && reg_sel == 4'h3) |=> (rd_ptr == AW'($past(din[AW-1:0]) + AW'(1))));

  assert_seq_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (reg_sel == 4'h0 || reg_sel == 4'h3)) |=> (seq == 2'd0));

  assert_readback_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !wr_evt && reg_sel == 4'h1 && !mode8) |=> (dout[CW-1:CW-2] == 2'b00));

  assert_pixel_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode8) |=> (pix_rgb[2*CW+1:2*CW] == 2'b00 && pix_rgb[CW+1:CW] == 2'b00 && pix_rgb[1:0] == 2'b00));
endmodule

bind palette_host_ctl palette_host_ctl_sva #(.AW(AW), .CW(CW)) u_sva (.*);

// File: tb/palette_host_ctl_bench.sv
module palette_host_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_strobe = 0, rd_strobe = 0, mode8 = 1;
  logic [3:0]  reg_sel = 0;
  logic [7:0]  din = 0, pix_idx = 0, dout;
  logic [23:0] pix_rgb;

  int checks = 0, fails = 0;

  logic [23:0] m_ram [256];
  logic [7:0]  m_wp, m_rp, m_mask;
  logic [1:0]  m_seq;
  logic [23:0] m_hold;
  logic [7:0]  m_ctl [8];

  palette_host_ctl u_palette_host_ctl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] shp_rd(logic [7:0] c, logic m8);
    return m8 ? c : {2'b00, c[5:0]};
  endfunction
  function automatic logic [23:0] shp_px(logic [23:0] e, logic m8);
    return m8 ? e : {e[21:16], 2'b00, e[13:8], 2'b00, e[5:0], 2'b00};
  endfunction
  function automatic logic ctl_code(logic [3:0] rs);
    return rs[3] && rs[2:0] != 3'd5 && rs[2:0] != 3'd7;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hw(logic [3:0] rs, logic [7:0] d, int hold_cyc = 5);
    @(negedge clk); reg_sel = rs; din = d; wr_strobe = 1;
    repeat (hold_cyc) @(negedge clk);
    wr_strobe = 0;
    repeat (3) @(negedge clk);
    case (rs)
      4'h0: begin m_wp = d; m_seq = 0; end
      4'h1: begin
        case (m_seq)
          2'd0: begin m_hold[23:16] = d; m_seq = 1; end
          2'd1: begin m_hold[15:8] = d; m_seq = 2; end
          default: begin m_hold[7:0] = d; m_ram[m_wp] = m_hold; m_wp++; m_seq = 0; end
        endcase
      end
      4'h2: m_mask = d;
      4'h3: begin m_hold = m_ram[d]; m_rp = d + 8'd1; m_seq = 0; end
      4'hF: for (int i = 0; i < 8; i++) m_ctl[i] = 0;
      default: if (ctl_code(rs)) m_ctl[rs[2:0]] = d;
    endcase
  endtask

  task automatic hr(logic [3:0] rs, string req);
    logic [7:0] exp;
    case (rs)
      4'h0: exp = m_wp;
      4'h1: exp = shp_rd(m_seq == 0 ? m_hold[23:16] : m_seq == 1 ? m_hold[15:8] : m_hold[7:0], mode8);
      4'h2: exp = m_mask;
      4'h3: exp = m_rp;
      default: exp = ctl_code(rs) ? m_ctl[rs[2:0]] : 8'h00;
    endcase
    @(negedge clk); reg_sel = rs; rd_strobe = 1;
    repeat (5) @(negedge clk);
    chk(req, {24'd0, dout}, {24'd0, exp});
    rd_strobe = 0;
    repeat (3) @(negedge clk);
    if (rs == 4'h1) begin
      if (m_seq == 2) begin m_seq = 0; m_hold = m_ram[m_rp]; m_rp++; end
      else m_seq++;
    end
  endtask

  task automatic px(logic [7:0] idx);
    @(negedge clk); pix_idx = idx;
    repeat (2) @(negedge clk);
    chk("R9 pixel", {8'd0, pix_rgb}, {8'd0, shp_px(m_ram[idx & m_mask], mode8)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    m_wp = 0; m_rp = 0; m_mask = 8'hFF; m_seq = 0; m_hold = 0;
    for (int i = 0; i < 8; i++) m_ctl[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 dout reset", {24'd0, dout}, 32'd0);
    chk("R11 pix reset", {8'd0, pix_rgb}, 32'd0);
    hr(4'h2, "R11 mask reset");
    hr(4'h0, "R11 wr ptr reset");
    hr(4'h8, "R11 ctl reset");

    hw(4'h0, 8'h00);
    for (int i = 0; i < 256 * 3; i++) hw(4'h1, 8'($urandom));
    hr(4'h0, "R6 wr ptr wrapped");

    hw(4'h3, 8'hFE);
    hr(4'h3, "R5 rd ptr after load");
    for (int i = 0; i < 6; i++) hr(4'h1, "R5 stream read");
    hr(4'h3, "R6 rd ptr wrapped");

    hw(4'h0, 8'h05); hw(4'h1, 8'hAA); hw(4'h1, 8'hBB);
    hw(4'h0, 8'h05); hw(4'h1, 8'hC1); hw(4'h1, 8'hD2); hw(4'h1, 8'hE3);
    hw(4'h3, 8'h05);
    for (int i = 0; i < 3; i++) hr(4'h1, "R7 restart at red");
    hw(4'h3, 8'h05); hr(4'h1, "R7 read restart");

    mode8 = 0;
    hw(4'h3, 8'h05);
    for (int i = 0; i < 3; i++) hr(4'h1, "R8 6-bit readback");
    mode8 = 1;
    hw(4'h3, 8'h05);
    hr(4'h1, "R8 full bits kept");

    hw(4'h9, 8'h5A); hw(4'hE, 8'hC3);
    hr(4'h9, "R2 ctl readback"); hr(4'hE, "R2 ctl readback");
    hw(4'h4, 8'h77); hw(4'hD, 8'h66);
    hr(4'h4, "R3 reserved reads 0"); hr(4'hD, "R3 reserved reads 0");
    hr(4'h9, "R3 reserved write no effect"); hr(4'h0, "R3 pointer untouched");
    hw(4'hF, 8'h00);
    hr(4'h9, "R3 clear code"); hr(4'hE, "R3 clear code");

    hw(4'h0, 8'h20);
    hw(4'h1, 8'h11, 25);
    hr(4'h0, "R10 long strobe single access");
    hw(4'h1, 8'h22); hw(4'h1, 8'h33);
    hr(4'h0, "R10 ptr after one entry");
    hw(4'h3, 8'h20); hr(4'h1, "R10 red is first byte");

    hw(4'h2, 8'h0F); hr(4'h2, "R1 mask readback");
    px(8'h35); mode8 = 0; px(8'hF7); mode8 = 1;
    hw(4'h2, 8'hFF); px(8'h05);

    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0: hw(4'h0, 8'($urandom));
        1: hw(4'h3, 8'($urandom));
        2, 3: hw(4'h1, 8'($urandom));
        4, 5: hr(4'h1, "R5 random hold read");
        6: hr(4'($urandom_range(0, 15)), "R1 random register read");
        7: hw(4'($urandom_range(8, 15)), 8'($urandom));
        8: begin mode8 = 1'($urandom); px(8'($urandom)); end
        default: begin hw(4'h2, 8'($urandom)); px(8'($urandom)); end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule